// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block takes one parallel character through a valid/ready handshake and sends it as an asynchronous NRZ frame on a single serial line. The frame is a low start bit, then 5 to 8 data bits in the chosen order, then an optional parity bit of the chosen polarity, then one or two high stop bits. When nothing is being sent, the line stays high.

The frame shape and the bit rate are both set by static configuration inputs. The block samples them, together with the character, on the clock edge that accepts the character, so later changes do not affect a frame that is already in flight. The bit time is built in two stages. A prescaler divides by 1, 2, 4 or 8. A reload counter then divides by a value from 2 to 255. The block is meant to sit behind a small data source that holds a character on `in_data` until it is taken.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, `txd` is high, `busy` is low and `in_ready` is high. While no frame is in flight, `txd` stays high.
- R2: On the clock edge where `in_valid` and `in_ready` are both high, the character is accepted. From that edge, `busy` is high and `txd` drives a low start bit for exactly one bit time.
- R3: `cfg_len` sets the character length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Only the low-order bits of `in_data` are sent.
- R4: With `cfg_msb_first` = 0, bit 0 of the character is sent first. With `cfg_msb_first` = 1, the highest active bit (bit length-1) is sent first.
- R5: With `cfg_par_en` = 1, a parity bit follows the last data bit. It is computed over the active data bits only. With `cfg_par_odd` = 0, the total count of ones (data plus parity) is even. With `cfg_par_odd` = 1, that count is odd. With `cfg_par_en` = 0, no parity bit is sent.
- R6: The frame ends with one high stop bit, or two when `cfg_two_stop` = 1. `busy` falls on the edge where the last stop bit ends, and `txd` stays high from then on.
- R7: Each bit lasts P x L system clocks and `txd` does not change within a bit. P is 1, 2, 4 or 8 for `cfg_presc` codes 00, 01, 10 and 11. L is `cfg_reload`, and reload values 0 and 1 act as 2.
- R8: The character and all configuration inputs are sampled only on the accepting edge. Changing them while a frame is in flight has no effect on that frame.
- R9: `in_ready` is low while `busy` is high, and `in_valid` is ignored during a frame. A new character is accepted on the first edge after `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Character available |
| in_ready | output | 1 | Block can accept a character |
| in_data | input | 8 | Character, low bits used for short lengths |
| cfg_len | input | 2 | Character length code (5..8 bits) |
| cfg_msb_first | input | 1 | 1 sends the highest active bit first |
| cfg_par_en | input | 1 | Append a parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| cfg_two_stop | input | 1 | 1 sends two stop bits |
| cfg_presc | input | 2 | Prescale select (divide by 1/2/4/8) |
| cfg_reload | input | 8 | Baud reload value, 2..255 |
| txd | output | 1 | Serial output line |
| busy | output | 1 | A frame is being sent |

## Verification
The bench checks every clock of every frame against a bit list that it builds itself. It targets the following mistakes:
- A design that picks the wrong data bits for MSB-first short characters would shift a high unused bit onto the line.
- A design that folds unused bits into parity would flip the parity bit for characters with junk in their upper bits.
- A prescaler or reload counter that is off by one would move every later edge.
- A design that keeps sampling the configuration would change the frame shape when the inputs are scrambled right after acceptance.

Two further cases get directed frames. A reload of 1 must be clamped to 2, and a long frame at the largest divide tests the counter range. Back-to-back frames show whether ready returns in time.

// File: rtl/uart_frame_tx.sv
module uart_frame_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic [1:0] cfg_len,
  input  logic       cfg_msb_first,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_two_stop,
  input  logic [1:0] cfg_presc,
  input  logic [7:0] cfg_reload,
  output logic       txd,
  output logic       busy
);
  localparam int DW = 8;
  localparam int FW = DW + 4;

  logic [FW-1:0] frame_c, sh;
  logic [3:0]    len, nbits, left;
  logic [2:0]    idx;
  logic          b, par;
  logic [1:0]    presc_q;
  logic [7:0]    rl_q;
  logic [2:0]    pcnt, pmax;
  logic [7:0]    bcnt;
  logic          pre_tick, bit_end, accept;

  assign len      = 4'd5 + {2'b00, cfg_len};
  assign nbits    = len + 4'd2 + {3'b000, cfg_par_en} + {3'b000, cfg_two_stop};
  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;
  assign txd      = busy ? sh[0] : 1'b1;

  always_comb begin
    frame_c    = '1;
    frame_c[0] = 1'b0;
    par        = cfg_par_odd;
    idx        = '0;
    b          = 1'b0;
    for (int i = 0; i < DW; i++) begin
      if (4'(i) < len) begin
        idx = cfg_msb_first ? 3'(len - 4'(i) - 4'd1) : 3'(i);
        b   = in_data[idx];
        frame_c[1+i] = b;
        par = par ^ b;
      end
    end
    if (cfg_par_en) frame_c[len + 4'd1] = par;
  end

  always_comb begin
    case (presc_q)
      2'd0:    pmax = 3'd0;
      2'd1:    pmax = 3'd1;
      2'd2:    pmax = 3'd3;
      default: pmax = 3'd7;
    endcase
  end

  assign pre_tick = busy && (pcnt == pmax);
  assign bit_end  = pre_tick && (bcnt == rl_q - 8'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      sh      <= '1;
      left    <= '0;
      presc_q <= '0;
      rl_q    <= 8'd2;
      pcnt    <= '0;
      bcnt    <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      sh      <= frame_c;
      left    <= nbits - 4'd1;
      presc_q <= cfg_presc;
      rl_q    <= (cfg_reload < 8'd2) ? 8'd2 : cfg_reload;
      pcnt    <= '0;
      bcnt    <= '0;
    end else if (busy) begin
      pcnt <= pre_tick ? 3'd0 : pcnt + 3'd1;
      if (pre_tick) bcnt <= bit_end ? 8'd0 : bcnt + 8'd1;
      if (bit_end) begin
        if (left == 4'd0) busy <= 1'b0;
        else begin
          sh   <= {1'b1, sh[FW-1:1]};
          left <= left - 4'd1;
        end
      end
    end
  end

  p_accept_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy && !txd);
  p_stop_before_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> txd && $past(txd));
  p_bit_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !bit_end |=> busy && $stable(txd));
  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bcnt < rl_q) && (pcnt <= pmax));
  p_no_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && in_valid && !bit_end |=> $stable(left) || (left == $past(left) - 4'd1));
endmodule

// File: tb/uart_frame_tx_test.sv
module uart_frame_tx_test;
  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [7:0] in_data = 0, cfg_reload = 2;
  logic [1:0] cfg_len = 0, cfg_presc = 0;
  logic cfg_msb_first = 0, cfg_par_en = 0, cfg_par_odd = 0, cfg_two_stop = 0;
  logic in_ready, txd, busy;
  int checks = 0, fails = 0, cyc = 0;

  always #5 clk = ~clk;

  uart_frame_tx uut (.clk, .rst_n, .in_valid, .in_ready, .in_data, .cfg_len,
    .cfg_msb_first, .cfg_par_en, .cfg_par_odd, .cfg_two_stop, .cfg_presc,
    .cfg_reload, .txd, .busy);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expect_bits(input logic [7:0] d, input logic [1:0] lc,
      input logic msb, pen, odd, two, output logic [11:0] bits);
    int n = 1, L = 5 + int'(lc), ones = 0;
    bits = '1;
    bits[0] = 1'b0;
    for (int k = 0; k < L; k++) begin
      int pos = msb ? L - 1 - k : k;
      bits[n] = d[pos];
      ones += int'(d[pos]);
      n++;
    end
    if (pen) begin
      bits[n] = (ones % 2 == 1) ^ odd;
      n++;
    end
    return n + 1 + int'(two);
  endfunction

  task automatic send(input logic [7:0] d, input logic [1:0] lc, input logic msb,
      pen, odd, two, input logic [1:0] ps, input logic [7:0] rl, input string tag);
    logic [11:0] bits;
    int n, T;
    n = expect_bits(d, lc, msb, pen, odd, two, bits);
    T = (1 << ps) * ((rl < 2) ? 2 : int'(rl));
    @(negedge clk);
    in_data = d; cfg_len = lc; cfg_msb_first = msb; cfg_par_en = pen;
    cfg_par_odd = odd; cfg_two_stop = two; cfg_presc = ps; cfg_reload = rl;
    in_valid = 1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    begin
      bit hold_ok = 1;
      for (int k = 0; k < n; k++) begin
        bit bit_ok = 1;
        logic got = 1'b0;
        for (int c = 0; c < T; c++) begin
          @(negedge clk);
          if (txd !== bits[k]) begin bit_ok = 0; got = txd; end
          if (!busy || in_ready) hold_ok = 0;
          if (k == 0 && c == 0) begin
            // R8: scramble inputs after acceptance; R9: valid held high is ignored
            in_data = 8'($urandom); cfg_len = 2'($urandom); cfg_msb_first = 1'($urandom);
            cfg_par_en = 1'($urandom); cfg_par_odd = 1'($urandom);
            cfg_two_stop = 1'($urandom); cfg_presc = 2'($urandom);
            cfg_reload = 8'($urandom);
          end
          if (k == n - 1 && c == T - 1) in_valid = 0;
        end
        chk(bit_ok, $sformatf("R2/R3/R4/R5/R6/R7/R8 %s bit %0d", tag, k),
            int'(bit_ok ? bits[k] : got), int'(bits[k]));
      end
      chk(hold_ok, $sformatf("R9 %s ready low and busy during frame", tag),
          int'(hold_ok), 1);
    end
    @(negedge clk);
    chk(!busy && txd && in_ready, $sformatf("R6 %s idle after last stop", tag),
        int'({busy, txd, in_ready}), 3);
  endtask

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    chk(txd === 1'b1 && busy === 1'b0 && in_ready === 1'b1, "R1 reset state",
        int'({txd, busy, in_ready}), 5);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(txd === 1'b1 && !busy, "R1 idle line stays high", int'(txd), 1);
    // directed: MSB-first short character with junk in upper bits
    send(8'hE5, 2'b00, 1, 1, 0, 0, 2'd0, 8'd3, "R3 R4 R5 short msb");
    send(8'hFF, 2'b11, 0, 1, 1, 1, 2'd1, 8'd2, "R5 odd all ones");
    send(8'h00, 2'b01, 0, 1, 0, 1, 2'd0, 8'd1, "R7 reload clamp");
    send(8'hA6, 2'b10, 1, 0, 0, 1, 2'd2, 8'd0, "R7 reload zero");
    send(8'h5A, 2'b11, 1, 1, 1, 1, 2'd3, 8'd255, "R7 max divide");
    for (int i = 0; i < 40; i++)
      send(8'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 2'($urandom), 8'($urandom_range(2, 6)), "rand");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule